// File: doc/BRIEF.md
# Two-Field Equivalence-Class Packet Classifier

This block classifies packets on two header fields (optionally three) by table indexing alone, with no comparison of rules at search time. Each field value goes through a small per-field map that returns a class ID. Field values that match exactly the same set of rules share a class ID. The pair of class IDs addresses a cross-product table, and each entry of that table already holds the best matching rule number. The result therefore costs one access per table and takes no priority search.

Software computes the classes and the table contents outside the block and loads them through one configuration write port. The search port is pipelined and accepts one packet per cycle. In two-field mode a search takes two cycles: the per-field maps are read in the first stage and the cross-product table in the second.

With `THREE_FIELD` set, the cross-product table holds a combined class ID in place of a rule number. That ID and the third field's class then address a final table that holds the rule, and latency grows to three cycles.

Top module: `eqc_classifier`

## Requirements
- R1: After reset `out_valid` is 0 and `out_rule` is the no-rule code 4'hF. Every field value maps to class 0. Every entry that yields a rule holds 4'hF, and in three-field mode every cross entry holds class 0. A search before any configuration therefore returns 4'hF.
- R2: Each 3-bit field value is looked up in its own 8-entry map, which returns a 2-bit class ID. Field values written with the same class always give the same result.
- R3: In two-field mode the result is the cross entry at flat address a*4+b, where a is the first field's class and b is the second field's class.
- R4: `out_valid` rises exactly 2 cycles after `in_valid` is sampled high (3 cycles in three-field mode). Results leave in order, one per cycle, under back-to-back input.
- R5: While `out_valid` is low, `out_rule` keeps its last value.
- R6: `cfg_table` selects the target of a write: 0 first-field map, 1 second-field map, 2 third-field map, 3 cross table, 4 final table. A map write uses `cfg_addr[2:0]` as the field value and `cfg_data[1:0]` as the class. A cross or final write uses `cfg_addr[3:0]` as the flat index and `cfg_data` as the value.
- R7: A configuration write changes only searches presented in later cycles. A search presented in the same cycle as a write sees the old contents of every table.
- R8: In three-field mode the cross entry at a*4+b supplies a combined class k (`cfg_data[1:0]`). The result is the final-table entry at k*4+c, where c is the third field's class.
- R9: Writes with `cfg_table` codes 5, 6 and 7 change no table.
- R10: In two-field mode the third field input, third-field map writes and final-table writes have no effect on results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_table | input | 3 | Target table select |
| cfg_addr | input | 4 | Field value or flat cross index |
| cfg_data | input | 4 | Class ID or rule number to write |
| in_valid | input | 1 | Search request strobe |
| in_f1 | input | 3 | First field value |
| in_f2 | input | 3 | Second field value |
| in_f3 | input | 3 | Third field value (three-field mode) |
| out_valid | output | 1 | Result strobe |
| out_rule | output | 4 | Best matching rule, 4'hF for no rule |

## Verification
A full 8x8 sweep of the first two fields runs against non-trivial maps, so that field values sharing a class can be told apart from values that only happen to land on equal entries. The sweep also shows whether the flat index takes a as the multiplied term or b. The sweep runs on a two-field instance and a three-field instance at once, so that the chained index through the combined class is checked next to the direct one. Writes to all five tables are interleaved with searches in the same cycle and in the cycle after, which separates old-contents behaviour from new-contents behaviour at each pipeline depth. Idle gaps, unused select codes and third-field changes show that the held output, the ignored writes and the ignored input in two-field mode really are inert.

// File: rtl/eqc_pkg.sv
package eqc_pkg;

    localparam int DEF_FIELD_W = 3;
    localparam int DEF_ID_W    = 2;
    localparam int DEF_RULE_W  = 4;

    // Configuration target codes; map codes equal the field number.
    typedef enum logic [2:0] {
        TBL_F1    = 3'd0,
        TBL_F2    = 3'd1,
        TBL_F3    = 3'd2,
        TBL_CROSS = 3'd3,
        TBL_FINAL = 3'd4
    } tbl_sel_e;

    // Multiplicative layout: first label scaled by the number of second labels.
    function automatic int unsigned flat_index(input int unsigned a,
                                               input int unsigned b,
                                               input int unsigned id_w);
        return a * (32'd1 << id_w) + b;
    endfunction

endpackage

// File: rtl/eqc_field_map.sv
module eqc_field_map #(
    parameter int KEY_W = 3,
    parameter int VAL_W = 2,
    parameter logic [VAL_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [KEY_W-1:0] waddr,
    input  logic [VAL_W-1:0] wdata,
    input  logic [KEY_W-1:0] raddr,
    output logic [VAL_W-1:0] rdata
);
    localparam int DEPTH = 1 << KEY_W;

    logic [VAL_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eqc_xprod_table.sv
module eqc_xprod_table #(
    parameter int ID_W     = 2,
    parameter int VAL_W    = 4,
    parameter logic [VAL_W-1:0] RST_VAL = '0,
    parameter int WR_DELAY = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [2*ID_W-1:0]   waddr,
    input  logic [VAL_W-1:0]    wdata,
    input  logic [ID_W-1:0]     ra,
    input  logic [ID_W-1:0]     rb,
    output logic [VAL_W-1:0]    rdata
);
    localparam int IDX_W = 2 * ID_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [VAL_W-1:0] mem [DEPTH];

    // Write delay line: aligns commit time with the read stage depth.
    logic [WR_DELAY-1:0] d_we;
    logic [IDX_W-1:0]    d_addr [WR_DELAY];
    logic [VAL_W-1:0]    d_data [WR_DELAY];

    genvar k;
    generate
        for (k = 0; k < WR_DELAY; k++) begin : g_dly
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) d_we[0] <= 1'b0;
                    else     d_we[0] <= we;
                    d_addr[0] <= waddr;
                    d_data[0] <= wdata;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) d_we[k] <= 1'b0;
                    else     d_we[k] <= d_we[k-1];
                    d_addr[k] <= d_addr[k-1];
                    d_data[k] <= d_data[k-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
        end else if (d_we[WR_DELAY-1]) begin
            mem[d_addr[WR_DELAY-1]] <= d_data[WR_DELAY-1];
        end
    end

    logic [IDX_W-1:0] ridx;
    assign ridx  = IDX_W'(eqc_pkg::flat_index(32'(ra), 32'(rb), ID_W));
    assign rdata = mem[ridx];
endmodule

// File: rtl/eqc_classifier.sv
module eqc_classifier #(
    parameter int FIELD_W     = eqc_pkg::DEF_FIELD_W,
    parameter int ID_W        = eqc_pkg::DEF_ID_W,
    parameter int RULE_W      = eqc_pkg::DEF_RULE_W,
    parameter bit THREE_FIELD = 1'b0,
    localparam int IDX_W      = 2 * ID_W,
    localparam int CFG_ADDR_W = (FIELD_W > IDX_W) ? FIELD_W : IDX_W,
    localparam int CFG_DATA_W = (RULE_W > ID_W) ? RULE_W : ID_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_table,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_data,
    input  logic                  in_valid,
    input  logic [FIELD_W-1:0]    in_f1,
    input  logic [FIELD_W-1:0]    in_f2,
    input  logic [FIELD_W-1:0]    in_f3,
    output logic                  out_valid,
    output logic [RULE_W-1:0]     out_rule
);
    import eqc_pkg::*;

    localparam int NUM_FIELDS = 3;
    localparam logic [RULE_W-1:0] NO_RULE = {RULE_W{1'b1}};

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] a;
        logic [ID_W-1:0] b;
        logic [ID_W-1:0] c;
    } cls_stage_t;

    // Write decode
    logic                  wr_cross, wr_final;
    logic [NUM_FIELDS-1:0] wr_map;
    assign wr_cross = cfg_we && (cfg_table == 3'(TBL_CROSS));
    assign wr_final = cfg_we && (cfg_table == 3'(TBL_FINAL));

    // Stage 1: per-field class lookup
    logic [FIELD_W-1:0] fld [NUM_FIELDS];
    logic [ID_W-1:0]    cls [NUM_FIELDS];
    assign fld[0] = in_f1;
    assign fld[1] = in_f2;
    assign fld[2] = in_f3;

    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_map
            assign wr_map[g] = cfg_we && (cfg_table == 3'(g));
            eqc_field_map #(
                .KEY_W   (FIELD_W),
                .VAL_W   (ID_W),
                .RST_VAL ('0)
            ) u_map (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_map[g]),
                .waddr (cfg_addr[FIELD_W-1:0]),
                .wdata (cfg_data[ID_W-1:0]),
                .raddr (fld[g]),
                .rdata (cls[g])
            );
        end
    endgenerate

    cls_stage_t s1_q;
    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= '{vld: in_valid, a: cls[0], b: cls[1], c: cls[2]};
    end

    logic              out_valid_q;
    logic [RULE_W-1:0] out_rule_q;

    generate
        if (!THREE_FIELD) begin : g_two
            logic [RULE_W-1:0] x_rule;
            eqc_xprod_table #(
                .ID_W     (ID_W),
                .VAL_W    (RULE_W),
                .RST_VAL  (NO_RULE),
                .WR_DELAY (1)
            ) u_cross (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_cross),
                .waddr (cfg_addr[IDX_W-1:0]),
                .wdata (cfg_data[RULE_W-1:0]),
                .ra    (s1_q.a),
                .rb    (s1_q.b),
                .rdata (x_rule)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid_q <= 1'b0;
                    out_rule_q  <= NO_RULE;
                end else begin
                    out_valid_q <= s1_q.vld;
                    if (s1_q.vld) out_rule_q <= x_rule;
                end
            end

            logic unused_two;
            assign unused_two = ^{s1_q.c, wr_final, cfg_addr, cfg_data};
        end else begin : g_three
            typedef struct packed {
                logic            vld;
                logic [ID_W-1:0] combo;
                logic [ID_W-1:0] c;
            } combo_stage_t;

            logic [ID_W-1:0]   x_combo;
            logic [RULE_W-1:0] y_rule;
            combo_stage_t      s2_q;

            eqc_xprod_table #(
                .ID_W     (ID_W),
                .VAL_W    (ID_W),
                .RST_VAL  ('0),
                .WR_DELAY (1)
            ) u_cross (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_cross),
                .waddr (cfg_addr[IDX_W-1:0]),
                .wdata (cfg_data[ID_W-1:0]),
                .ra    (s1_q.a),
                .rb    (s1_q.b),
                .rdata (x_combo)
            );

            always_ff @(posedge clk) begin
                if (rst) s2_q <= '0;
                else     s2_q <= '{vld: s1_q.vld, combo: x_combo, c: s1_q.c};
            end

            eqc_xprod_table #(
                .ID_W     (ID_W),
                .VAL_W    (RULE_W),
                .RST_VAL  (NO_RULE),
                .WR_DELAY (2)
            ) u_final (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_final),
                .waddr (cfg_addr[IDX_W-1:0]),
                .wdata (cfg_data[RULE_W-1:0]),
                .ra    (s2_q.combo),
                .rb    (s2_q.c),
                .rdata (y_rule)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid_q <= 1'b0;
                    out_rule_q  <= NO_RULE;
                end else begin
                    out_valid_q <= s2_q.vld;
                    if (s2_q.vld) out_rule_q <= y_rule;
                end
            end

            logic unused_three;
            assign unused_three = ^{cfg_addr, cfg_data};
        end
    endgenerate

    assign out_valid = out_valid_q;
    assign out_rule  = out_rule_q;
endmodule

// File: rtl/eqc_classifier_chk.sv
module eqc_classifier_chk #(
    parameter bit THREE_FIELD = 1'b0,
    parameter int RULE_W      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [RULE_W-1:0] out_rule
);
    localparam int LAT = THREE_FIELD ? 3 : 2;
    localparam logic [RULE_W-1:0] NO_RULE = {RULE_W{1'b1}};

    logic [LAT-1:0] vpipe;
    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_rule == NO_RULE));

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid == vpipe[LAT-1]);

    assert_rise_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid, LAT));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_rule));
endmodule

bind eqc_classifier eqc_classifier_chk #(
    .THREE_FIELD (THREE_FIELD),
    .RULE_W      (RULE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_rule  (out_rule)
);

// File: tb/eqc_classifier_tb.sv
module eqc_classifier_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_table = '0;
    logic [3:0] cfg_addr = '0;
    logic [3:0] cfg_data = '0;
    logic       in_valid = 1'b0;
    logic [2:0] in_f1 = '0, in_f2 = '0, in_f3 = '0;
    logic       ov2, ov3;
    logic [3:0] rule2, rule3;

    always #4 clk = ~clk;   // 125 MHz

    eqc_classifier u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_table(cfg_table),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_f1(in_f1), .in_f2(in_f2), .in_f3(in_f3),
        .out_valid(ov2), .out_rule(rule2)
    );

    eqc_classifier #(.THREE_FIELD(1'b1)) u_dut3 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_table(cfg_table),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_f1(in_f1), .in_f2(in_f2), .in_f3(in_f3),
        .out_valid(ov3), .out_rule(rule3)
    );

    typedef struct {
        int    rule;
        int    cyc;
        string tag;
    } exp_t;

    exp_t q2[$];
    exp_t q3[$];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last2  = 15;
    int last3  = 15;
    bit done   = 1'b0;

    // Bench-side model of table contents
    int m_map [3][8];
    int mx2 [16];
    int mx3 [16];
    int my  [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; expected results use contents
    // before this cycle's write (R7).
    task automatic step(input bit we, input int sel, input int addr,
                        input int data, input bit v, input int f1,
                        input int f2, input int f3, input string tag);
        int a, b, c;
        cfg_we    = we;
        cfg_table = 3'(sel);
        cfg_addr  = 4'(addr);
        cfg_data  = 4'(data);
        in_valid  = v;
        in_f1     = 3'(f1);
        in_f2     = 3'(f2);
        in_f3     = 3'(f3);
        if (v) begin
            a = m_map[0][f1];
            b = m_map[1][f2];
            c = m_map[2][f3];
            q2.push_back('{mx2[a*4+b], cyc, tag});
            q3.push_back('{my[mx3[a*4+b]*4+c], cyc, tag});
        end
        if (we) begin
            case (sel)
                0, 1, 2: m_map[sel][addr & 7] = data & 3;
                3: begin mx2[addr & 15] = data & 15; mx3[addr & 15] = data & 3; end
                4: my[addr & 15] = data & 15;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "");
    endtask

    // Monitor: scoreboard compare at the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ov2) begin
                if (q2.size() == 0) check(1'b0, "R4", "2f unexpected result", 1, 0);
                else begin
                    exp_t e;
                    e = q2.pop_front();
                    check(int'(rule2) == e.rule, e.tag, "2f rule", int'(rule2), e.rule);
                    check(cyc == e.cyc + 2, "R4", "2f latency", cyc - e.cyc, 2);
                    last2 = int'(rule2);
                end
            end else begin
                check(int'(rule2) == last2, "R5", "2f held rule", int'(rule2), last2);
            end
            if (ov3) begin
                if (q3.size() == 0) check(1'b0, "R4", "3f unexpected result", 1, 0);
                else begin
                    exp_t e;
                    e = q3.pop_front();
                    check(int'(rule3) == e.rule, e.tag, "3f rule", int'(rule3), e.rule);
                    check(cyc == e.cyc + 3, "R4", "3f latency", cyc - e.cyc, 3);
                    last3 = int'(rule3);
                end
            end else begin
                check(int'(rule3) == last3, "R5", "3f held rule", int'(rule3), last3);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 8; j++) m_map[i][j] = 0;
        for (int i = 0; i < 16; i++) begin
            mx2[i] = 15;
            mx3[i] = 0;
            my[i]  = 15;
        end

        repeat (4) @(negedge clk);
        // R1: reset state seen during reset
        check(ov2 == 1'b0 && ov3 == 1'b0, "R1", "valid in reset", int'(ov2) + int'(ov3), 0);
        check(rule2 == 4'hF, "R1", "2f rule in reset", int'(rule2), 15);
        check(rule3 == 4'hF, "R1", "3f rule in reset", int'(rule3), 15);
        rst = 1'b0;
        @(negedge clk);

        // R1: search before any configuration
        step(1'b0, 0, 0, 0, 1'b1, 1, 2, 3, "R1");
        step(1'b0, 0, 0, 0, 1'b1, 7, 5, 6, "R1");

        // R6: load the maps and both pair tables
        for (int v = 0; v < 8; v++) step(1'b1, 0, v, v >> 1, 1'b0, 0, 0, 0, "");
        for (int v = 0; v < 8; v++) step(1'b1, 1, v, (v + 1) & 3, 1'b0, 0, 0, 0, "");
        for (int v = 0; v < 8; v++) step(1'b1, 2, v, (v & 3) ^ (v >> 2), 1'b0, 0, 0, 0, "");
        for (int i = 0; i < 16; i++) step(1'b1, 3, i, (i * 5 + 3) % 15, 1'b0, 0, 0, 0, "");
        for (int i = 0; i < 16; i++) step(1'b1, 4, i, (i * 7 + 1) % 16, 1'b0, 0, 0, 0, "");

        // R2 R3 R8: full sweep, back to back
        for (int f1 = 0; f1 < 8; f1++)
            for (int f2 = 0; f2 < 8; f2++)
                step(1'b0, 0, 0, 0, 1'b1, f1, f2, (f1 + f2) % 8, "R2 R3 R8");

        // R7: write and search in the same cycle, then search again
        step(1'b1, 3, 4, 9, 1'b1, 2, 3, 1, "R7");
        step(1'b0, 0, 0, 0, 1'b1, 2, 3, 1, "R7");
        step(1'b1, 0, 2, 3, 1'b1, 2, 3, 1, "R7");
        step(1'b0, 0, 0, 0, 1'b1, 2, 3, 1, "R7");
        step(1'b1, 4, 5, 12, 1'b1, 4, 0, 1, "R7");
        step(1'b0, 0, 0, 0, 1'b1, 4, 0, 1, "R7");
        for (int i = 0; i < 24; i++)
            step(1'b1, i % 5, (i * 3) % 16, (i * 11) % 16, 1'b1,
                 i % 8, (i * 3) % 8, (i * 5) % 8, "R6 R7");

        // R9: unused select codes
        for (int s = 5; s < 8; s++)
            for (int i = 0; i < 16; i++) step(1'b1, s, i, 0, 1'b0, 0, 0, 0, "");
        for (int f1 = 0; f1 < 8; f1++)
            for (int f2 = 0; f2 < 8; f2 += 3)
                step(1'b0, 0, 0, 0, 1'b1, f1, f2, f1, "R9");

        // R10: third field and final-table writes inert in two-field mode
        for (int f3 = 0; f3 < 8; f3++) begin
            step(1'b1, 4, f3 * 2, f3, 1'b1, 3, 6, f3, "R10");
            step(1'b1, 2, f3, 3 - (f3 & 3), 1'b1, 5, 1, f3, "R10");
        end

        // R5: sparse searches with idle gaps
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 0, 0, 0, 1'b1, (i * 3) % 8, (i * 5) % 8, i % 8, "R5 R4");
            repeat (i % 3 + 1) idle();
        end

        repeat (6) idle();
        check(q2.size() == 0, "R4", "2f results missing", q2.size(), 0);
        check(q3.size() == 0, "R4", "3f results missing", q3.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule